// File: doc/BRIEF.md
# Registered Bidirectional Parity Transceiver

This block connects two ports, A and B, through two independent paths: A-to-B and B-to-A. Each path is split into lanes. A lane holds a data byte plus one parity bit. Each path has its own clock, latch enable and per-lane clock enables, so every path can run in one of three modes:

- transparent: the input flows straight through;
- clocked: the input is captured on the rising edge;
- held: the stored value is kept.

The bidirectional pins are modelled as separate input, output and output-enable signals.

A shared parity control, active low, turns on parity handling for both paths. With parity on, each outgoing lane carries a freshly computed parity bit in place of the one that came in. The received parity on each side is checked, and an active-low error flag per side reports any lane mismatch. An odd/even select sets the sense of both generation and checking. With parity off, all bits pass unchanged and both error flags stay high.

Top module: `ptx_xcvr`

## Requirements
- R1: Lane k occupies bits [9k+8:9k] of a port vector, with data in [9k+7:9k] and the parity bit at 9k+8. While a path's latch enable is high, its output follows its input in the same cycle, and its storage loads the input at every rising edge of the path clock.
- R2: While the latch enable is low and a lane's active-low clock enable is low, that lane's input is stored at the rising edge. From then on, the output shows the stored value.
- R3: While the latch enable is low and a lane's clock enable is high, the lane's stored value and output do not change, whatever the input does.
- R4: Each lane's clock enable affects only its own lane.
- R5: The A-to-B and B-to-A paths use separate clocks and controls. Activity on one path leaves the other unchanged.
- R6: With the parity enable high, every output bit equals the selected stored or transparent bit, and both error outputs stay high.
- R7: With the parity enable low, bit 9k+8 of each driven output lane is replaced by a generated parity bit. When the odd select is 1, the nine bits hold an odd number of ones; when it is 0, an even number.
- R8: With the parity enable low, the A-side error output goes low in the same cycle if any lane of the A input breaks the selected parity. The B-side error output does the same for the B input.
- R9: An output enable held high forces its output vector to zero and its drive flag low. Held low, the vector is driven and the flag is high (B port for A-to-B, A port for B-to-A).
- R10: A synchronous reset clears all stored lane values to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | A-to-B storage clock |
| clk_ba | input | 1 | B-to-A storage clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data received on port A |
| a_out | output | 18 | Data driven onto port A (B-to-A path) |
| a_oe | output | 1 | Port A drive flag |
| b_in | input | 18 | Data received on port B |
| b_out | output | 18 | Data driven onto port B (A-to-B path) |
| b_oe | output | 1 | Port B drive flag |
| le_ab | input | 1 | A-to-B latch enable (high = transparent) |
| le_ba | input | 1 | B-to-A latch enable |
| ce_ab_n | input | 2 | A-to-B per-lane clock enables, active low |
| ce_ba_n | input | 2 | B-to-A per-lane clock enables, active low |
| oe_ab_n | input | 1 | Output enable for B port, active low |
| oe_ba_n | input | 1 | Output enable for A port, active low |
| par_en_n | input | 1 | Parity enable, active low |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| err_a_n | output | 1 | Parity error on A input, active low |
| err_b_n | output | 1 | Parity error on B input, active low |

## Verification
The hardest state to reach is a path that has left transparent mode with lanes in different states: one lane holding an old capture while its neighbour clocks in new data, and parity generation switched on over the held contents. Random latch enables alone rarely produce this. The stimulus therefore biases the latch enable low and draws lane clock enables separately, and directed sequences capture one lane only, then turn parity on over the held value. Error flags are exercised by random parity bits on both inputs, together with directed single-lane corruptions.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
   // Parity bit that makes data plus parity match the selected sense.
   function automatic logic gen_parity(input logic [63:0] data, input int unsigned width,
                                       input logic odd);
      logic p;
      p = odd;
      for (int i = 0; i < 64; i++)
         if (i < int'(width)) p = p ^ data[i];
      return p;
   endfunction
endpackage

// File: rtl/ptx_lane_store.sv
module ptx_lane_store #(
   parameter int LW = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          le,
   input  logic          ce_n,
   input  logic [LW-1:0] d,
   output logic [LW-1:0] q
);
   logic [LW-1:0] q_reg;

   always_ff @(posedge clk) begin
      if (rst)
         q_reg <= '0;
      else if (le || !ce_n)
         q_reg <= d;
   end

   // transparent while le is high, otherwise the stored value
   assign q = le ? d : q_reg;
endmodule

// File: rtl/ptx_lane_par.sv
module ptx_lane_par #(
   parameter int DW         = 8,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic        par_on,
   input  logic        odd,
   input  logic [DW:0] tx,
   input  logic [DW:0] rx,
   output logic [DW:0] tx_out,
   output logic        rx_bad
);
   import ptx_pkg::*;

   generate
      if (HAS_PARITY) begin : g_par
         logic tx_p, rx_p;
         always_comb begin
            tx_p = gen_parity(64'(tx[DW-1:0]), DW, odd);
            rx_p = gen_parity(64'(rx[DW-1:0]), DW, odd);
         end
         assign tx_out = par_on ? {tx_p, tx[DW-1:0]} : tx;
         assign rx_bad = par_on && (rx_p != rx[DW]);
      end else begin : g_thru
         assign tx_out = tx;
         assign rx_bad = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ptx_dir.sv
module ptx_dir #(
   parameter int LANES      = 2,
   parameter int DW         = 8,
   parameter bit HAS_PARITY = 1'b1,
   localparam int LW        = DW + 1,
   localparam int W         = LANES * LW
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             le,
   input  logic [LANES-1:0] ce_n,
   input  logic             oe_n,
   input  logic             par_on,
   input  logic             odd,
   input  logic [W-1:0]     din,
   input  logic [W-1:0]     rx_chk,
   output logic [W-1:0]     dout,
   output logic             doe,
   output logic             rx_err
);
   logic [W-1:0]     staged;
   logic [W-1:0]     framed;
   logic [LANES-1:0] bad;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         ptx_lane_store #(.LW(LW)) u_store (
            .clk (clk),
            .rst (rst),
            .le  (le),
            .ce_n(ce_n[l]),
            .d   (din[l*LW +: LW]),
            .q   (staged[l*LW +: LW])
         );
         ptx_lane_par #(.DW(DW), .HAS_PARITY(HAS_PARITY)) u_par (
            .par_on(par_on),
            .odd   (odd),
            .tx    (staged[l*LW +: LW]),
            .rx    (rx_chk[l*LW +: LW]),
            .tx_out(framed[l*LW +: LW]),
            .rx_bad(bad[l])
         );
      end
   endgenerate

   assign dout   = oe_n ? '0 : framed;
   assign doe    = !oe_n;
   assign rx_err = |bad;
endmodule

// File: rtl/ptx_xcvr.sv
module ptx_xcvr #(
   parameter int LANES      = 2,
   parameter int DW         = 8,
   parameter bit HAS_PARITY = 1'b1,
   localparam int W         = LANES * (DW + 1)
) (
   input  logic             clk_ab,
   input  logic             clk_ba,
   input  logic             rst,
   input  logic [W-1:0]     a_in,
   output logic [W-1:0]     a_out,
   output logic             a_oe,
   input  logic [W-1:0]     b_in,
   output logic [W-1:0]     b_out,
   output logic             b_oe,
   input  logic             le_ab,
   input  logic             le_ba,
   input  logic [LANES-1:0] ce_ab_n,
   input  logic [LANES-1:0] ce_ba_n,
   input  logic             oe_ab_n,
   input  logic             oe_ba_n,
   input  logic             par_en_n,
   input  logic             odd_sel,
   output logic             err_a_n,
   output logic             err_b_n
);
   generate
      if (LANES < 1 || DW < 1 || DW > 63) begin : g_bad_cfg
         $error("ptx_xcvr: LANES must be >= 1 and DW in 1..63");
      end
   endgenerate

   logic par_on;
   logic err_a, err_b;

   assign par_on = !par_en_n;

   // A-to-B path checks what arrives on A
   ptx_dir #(.LANES(LANES), .DW(DW), .HAS_PARITY(HAS_PARITY)) u_ab (
      .clk   (clk_ab),
      .rst   (rst),
      .le    (le_ab),
      .ce_n  (ce_ab_n),
      .oe_n  (oe_ab_n),
      .par_on(par_on),
      .odd   (odd_sel),
      .din   (a_in),
      .rx_chk(a_in),
      .dout  (b_out),
      .doe   (b_oe),
      .rx_err(err_a)
   );

   // B-to-A path checks what arrives on B
   ptx_dir #(.LANES(LANES), .DW(DW), .HAS_PARITY(HAS_PARITY)) u_ba (
      .clk   (clk_ba),
      .rst   (rst),
      .le    (le_ba),
      .ce_n  (ce_ba_n),
      .oe_n  (oe_ba_n),
      .par_on(par_on),
      .odd   (odd_sel),
      .din   (b_in),
      .rx_chk(b_in),
      .dout  (a_out),
      .doe   (a_oe),
      .rx_err(err_b)
   );

   assign err_a_n = !err_a;
   assign err_b_n = !err_b;
endmodule

// File: rtl/ptx_xcvr_chk.sv
module ptx_xcvr_chk #(
   parameter int LANES      = 2,
   parameter int DW         = 8,
   parameter bit HAS_PARITY = 1'b1,
   localparam int LW        = DW + 1,
   localparam int W         = LANES * LW
) (
   input logic             clk_ab,
   input logic             clk_ba,
   input logic             rst,
   input logic [W-1:0]     a_in,
   input logic [W-1:0]     a_out,
   input logic             a_oe,
   input logic [W-1:0]     b_in,
   input logic [W-1:0]     b_out,
   input logic             b_oe,
   input logic             le_ab,
   input logic             le_ba,
   input logic [LANES-1:0] ce_ab_n,
   input logic [LANES-1:0] ce_ba_n,
   input logic             oe_ab_n,
   input logic             oe_ba_n,
   input logic             par_en_n,
   input logic             odd_sel,
   input logic             err_a_n,
   input logic             err_b_n
);
   // R1 / R6: transparent bypass copies input to output
   a_r1_transparent_ab: assert property (@(posedge clk_ab) disable iff (rst)
      (le_ab && par_en_n && !oe_ab_n) |-> (b_out == a_in));
   a_r1_transparent_ba: assert property (@(posedge clk_ba) disable iff (rst)
      (le_ba && par_en_n && !oe_ba_n) |-> (a_out == b_in));

   // R6: errors inactive with parity off
   a_r6_err_idle: assert property (@(posedge clk_ab) disable iff (rst)
      par_en_n |-> (err_a_n && err_b_n));

   // R9: output enable behaviour
   a_r9_oe_off_ab: assert property (@(posedge clk_ab) disable iff (rst)
      oe_ab_n |-> (b_out == '0 && !b_oe));
   a_r9_oe_on_ab: assert property (@(posedge clk_ab) disable iff (rst)
      !oe_ab_n |-> b_oe);
   a_r9_oe_off_ba: assert property (@(posedge clk_ba) disable iff (rst)
      oe_ba_n |-> (a_out == '0 && !a_oe));

   generate
      if (HAS_PARITY) begin : g_pchk
         for (genvar l = 0; l < LANES; l++) begin : g_lane
            // R7: generated parity matches selected sense
            a_r7_gen_ab: assert property (@(posedge clk_ab) disable iff (rst)
               (!par_en_n && !oe_ab_n) |-> ((^b_out[l*LW +: LW]) == odd_sel));
            // R8: a bad received lane pulls the side error low
            a_r8_chk_a: assert property (@(posedge clk_ab) disable iff (rst)
               (!par_en_n && ((^a_in[l*LW +: LW]) != odd_sel)) |-> !err_a_n);
            a_r8_chk_b: assert property (@(posedge clk_ba) disable iff (rst)
               (!par_en_n && ((^b_in[l*LW +: LW]) != odd_sel)) |-> !err_b_n);
            // R2: clocked capture shows up after the edge
            a_r2_capture_ab: assert property (@(posedge clk_ab) disable iff (rst)
               (!le_ab && !ce_ab_n[l] && !oe_ab_n && par_en_n) |=>
               (le_ab || oe_ab_n || !par_en_n ||
                b_out[l*LW +: LW] == $past(a_in[l*LW +: LW])));
            // R3: held lane does not move
            a_r3_hold_ab: assert property (@(posedge clk_ab) disable iff (rst)
               (!le_ab && ce_ab_n[l] && !oe_ab_n) |=>
               (le_ab || oe_ab_n || !$stable(par_en_n) || !$stable(odd_sel) ||
                $stable(b_out[l*LW +: LW])));
         end
      end
   endgenerate
endmodule

bind ptx_xcvr ptx_xcvr_chk #(.LANES(LANES), .DW(DW), .HAS_PARITY(HAS_PARITY)) u_chk (.*);

// File: tb/ptx_xcvr_bench.sv
module ptx_xcvr_bench;
   localparam int L  = 2;
   localparam int DW = 8;
   localparam int LW = DW + 1;
   localparam int W  = L * LW;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic [W-1:0] a_out, b_out;
   logic a_oe, b_oe, err_a_n, err_b_n;
   logic le_ab = 0, le_ba = 0, oe_ab_n = 0, oe_ba_n = 0, par_en_n = 1, odd_sel = 0;
   logic [L-1:0] ce_ab_n = '1, ce_ba_n = '1;

   int checks = 0, fails = 0;
   logic [W-1:0] m_ab = '0, m_ba = '0;
   bit done = 0;

   always #2 clk = ~clk;

   ptx_xcvr #(.LANES(L), .DW(DW)) u_ptx_xcvr (
      .clk_ab(clk), .clk_ba(clk), .rst(rst),
      .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
      .le_ab(le_ab), .le_ba(le_ba), .ce_ab_n(ce_ab_n), .ce_ba_n(ce_ba_n),
      .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n), .par_en_n(par_en_n),
      .odd_sel(odd_sel), .err_a_n(err_a_n), .err_b_n(err_b_n)
   );

   // reference storage, from R1/R2/R3/R10
   always @(posedge clk) begin
      for (int l = 0; l < L; l++) begin
         if (rst) begin
            m_ab[l*LW +: LW] <= '0;
            m_ba[l*LW +: LW] <= '0;
         end else begin
            if (le_ab || !ce_ab_n[l]) m_ab[l*LW +: LW] <= a_in[l*LW +: LW];
            if (le_ba || !ce_ba_n[l]) m_ba[l*LW +: LW] <= b_in[l*LW +: LW];
         end
      end
   end

   function automatic logic [W-1:0] exp_out(input logic [W-1:0] din, input logic [W-1:0] st,
                                            input logic le, input logic oe_n);
      logic [W-1:0] v;
      if (oe_n) return '0;
      v = le ? din : st;
      if (!par_en_n)
         for (int l = 0; l < L; l++) v[l*LW + DW] = (^v[l*LW +: DW]) ^ odd_sel;
      return v;
   endfunction

   function automatic logic exp_err_n(input logic [W-1:0] din);
      if (par_en_n) return 1'b1;
      for (int l = 0; l < L; l++)
         if (din[l*LW + DW] != ((^din[l*LW +: DW]) ^ odd_sel)) return 1'b0;
      return 1'b1;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(input string force_tag);
      string t_ab, t_ba;
      t_ab = oe_ab_n ? "R9" : !par_en_n ? "R7" : le_ab ? "R1" : "R2/R3";
      t_ba = oe_ba_n ? "R9" : !par_en_n ? "R7" : le_ba ? "R1" : "R2/R3";
      if (force_tag != "") begin t_ab = force_tag; t_ba = force_tag; end
      check({t_ab, " b_out"}, b_out, exp_out(a_in, m_ab, le_ab, oe_ab_n));
      check({t_ba, " a_out"}, a_out, exp_out(b_in, m_ba, le_ba, oe_ba_n));
      check("R9 drive flags", {16'(0), a_oe, b_oe}, {16'(0), !oe_ba_n, !oe_ab_n});
      check(par_en_n ? "R6 err flags" : "R8 err flags", {16'(0), err_a_n, err_b_n},
            {16'(0), exp_err_n(a_in), exp_err_n(b_in)});
   endtask

   // inputs set just after a falling edge; sample 1 ns later, well before the rising edge
   task automatic step(input string tag);
      #1;
      check_all(tag);
      @(negedge clk);
   endtask

   function automatic logic [W-1:0] good_par(input logic [W-1:0] v, input logic odd);
      logic [W-1:0] r = v;
      for (int l = 0; l < L; l++) r[l*LW + DW] = (^v[l*LW +: DW]) ^ odd;
      return r;
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0147));
      @(negedge clk);
      rst = 1; a_in = '1; b_in = '1;
      @(negedge clk); @(negedge clk);
      rst = 0; le_ab = 0; le_ba = 0; ce_ab_n = '1; ce_ba_n = '1;
      // R10: after reset the held storage is zero
      step("R10");
      check("R10 b_out zero", b_out, '0);

      // R4: capture lane 0 only on A-to-B
      a_in = 18'h2_A5A5; ce_ab_n = 2'b10;
      step("R4");
      ce_ab_n = 2'b11; a_in = '0;
      step("R4");
      check("R4 lane1 untouched", {9'h0, b_out[17:9]}, '0);
      check("R4 lane0 captured", {9'h0, b_out[8:0]}, {9'h0, 9'h1A5});

      // R5: run B-to-A transparent while A-to-B holds
      le_ba = 1; b_in = 18'h1_2345;
      step("R5"); b_in = 18'h3_FFFF; step("R5");
      le_ba = 0;
      step("R5");

      // R7: parity turned on over held contents, both senses
      par_en_n = 0; odd_sel = 0; step("R7");
      odd_sel = 1; step("R7");

      // R8: one bad lane per side
      a_in = good_par(18'h0_1234, 1); a_in[17] = ~a_in[17]; step("R8");
      b_in = good_par(18'h0_00FF, 1); b_in[8] = ~b_in[8]; step("R8");
      b_in = good_par(18'h0_00FF, 1); step("R8");

      // R9: both outputs released
      oe_ab_n = 1; oe_ba_n = 1; step("R9");
      oe_ab_n = 0; oe_ba_n = 0; par_en_n = 1; step("R6");

      // random phase
      for (int i = 0; i < 3000; i++) begin
         a_in = W'({$urandom, $urandom});
         b_in = W'({$urandom, $urandom});
         if ($urandom_range(1)) a_in = good_par(a_in, odd_sel);
         if ($urandom_range(1)) b_in = good_par(b_in, odd_sel);
         le_ab = ($urandom_range(3) == 0);
         le_ba = ($urandom_range(3) == 0);
         ce_ab_n = L'($urandom);
         ce_ba_n = L'($urandom);
         oe_ab_n = ($urandom_range(9) == 0);
         oe_ba_n = ($urandom_range(9) == 0);
         if (i % 50 == 0) par_en_n = $urandom_range(1);
         if ($urandom_range(7) == 0) odd_sel = ~odd_sel;
         rst = ($urandom_range(99) == 0);
         step(rst ? "R10" : "");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule